// File: doc/BRIEF.md
# Masked Event Status Controller

This block gathers a set of single-bit event sources into a latched pending word. Software picks the events it cares about through a selection mask, and it clears handled events by writing their bits to an acknowledge port. A status read returns the pending word filtered by the mask and stalls while nothing selected is pending. A one-bit count output answers the same question without stalling. An interrupt request is raised while interrupts are enabled and a selected event is pending. The handler entry address is fixed.

A 32-bit down-counter is built in. Software loads it with a new count, and it then steps down by one every clock. The step from zero to all ones (a positive-to-negative sign change) posts its own event bit. External sources are captured on their rising edges, so a level that stays high does not post the event again after it has been acknowledged.

Top module: `evt_status_ctrl`

## Requirements
- R1: After reset, the pending word and the mask are zero, and interrupts are disabled. `irq`, `statCount` and `statRdValid` are 0, and `decValue` is all ones.
- R2: A rising edge on `srcIn[i]` sets pending bit i on the next clock edge. A source held high does not set the bit again after it has been acknowledged.
- R3: `statRdData` equals the pending word ANDed with the mask, so unselected bits read zero. A mask write takes effect on the next clock edge, and `maskOut` returns the mask.
- R4: `statCount` is 1 when any selected event is pending and 0 otherwise.
- R5: While `statRdReq` is high and no selected event is pending, `statRdValid` stays 0. `statRdValid` goes to 1 in the first cycle in which a selected event is pending.
- R6: Writing the acknowledge port clears the pending bits set in `ackWrData` at the next edge and leaves the other bits unchanged. A later rising edge sets a cleared bit again.
- R7: When a source rises in the same cycle in which its bit is acknowledged, the bit stays pending.
- R8: Writing the down-counter loads `decWrData` at the next edge. In every cycle without a write, the counter decreases by one.
- R9: Pending bit 4 is set when the counter steps from 0 to all ones. Loading a negative value, and counting down from one negative value to another, post no event. `srcIn[4]` also sets bit 4 on its rising edge.
- R10: `intEnSet` turns interrupts on and `intEnClr` turns them off; when both are high, clear wins. `irq` is high exactly when interrupts are on and a selected event is pending.
- R11: `irqVec` always presents the handler entry address 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 12 | Event source levels |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrData | input | 12 | New mask value |
| maskOut | output | 12 | Current mask |
| ackWrEn | input | 1 | Acknowledge write strobe |
| ackWrData | input | 12 | Bits to clear from the pending word |
| statRdReq | input | 1 | Status read request, held until served |
| statRdValid | output | 1 | Status read served this cycle |
| statRdData | output | 12 | Masked pending word |
| statCount | output | 1 | 1 if any selected event is pending |
| intEnSet | input | 1 | Enable interrupts |
| intEnClr | input | 1 | Disable interrupts |
| irq | output | 1 | Interrupt request |
| irqVec | output | 16 | Handler entry address |
| decWrEn | input | 1 | Down-counter load strobe |
| decWrData | input | 32 | Down-counter load value |
| decValue | output | 32 | Down-counter value |

## Verification
The bench drives a source rise and its acknowledge in the same cycle. A design that gives the clear priority would lose that event. It holds a source high across an acknowledge, which catches a design that latches levels and re-fires at once. It counts the down-counter through the zero crossing and loads a negative value. A design that tested the sign bit, or fired on any load, would post the event at the wrong time. It also holds a status read with nothing pending, sets and clears enable in the same cycle, and changes the mask under a pending event. Together these expose a read that does not stall, the wrong enable priority, and an interrupt that ignores the mask.

// File: rtl/evt_pkg.sv
package evt_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic maskWr;
    logic ackWr;
    logic decLoad;
  } dpStrobes_t;
endpackage

// File: rtl/evt_datapath.sv
module evt_datapath
  import evt_pkg::*;
#(
  parameter int NUM_EVT = 12,
  parameter int DEC_W   = 32,
  parameter int DEC_BIT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strb,
  input  logic [NUM_EVT-1:0] srcIn,
  input  logic [NUM_EVT-1:0] maskWrData,
  input  logic [NUM_EVT-1:0] ackWrData,
  input  logic [DEC_W-1:0]   decWrData,
  output logic [NUM_EVT-1:0] maskOut,
  output logic [NUM_EVT-1:0] selPending,
  output logic               anySel,
  output logic [DEC_W-1:0]   decValue
);
  logic [NUM_EVT-1:0] maskReg, pendReg, srcPrev, riseVec, setVec, clrVec;
  logic [DEC_W-1:0]   decReg;
  logic               decFire;

  assign riseVec = srcIn & ~srcPrev;
  assign decFire = !strb.decLoad && (decReg == '0);
  assign clrVec  = strb.ackWr ? ackWrData : '0;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_set
    if (g == DEC_BIT) begin : g_dec
      assign setVec[g] = riseVec[g] | decFire;
    end else begin : g_ext
      assign setVec[g] = riseVec[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      pendReg <= '0;
      srcPrev <= '0;
      decReg  <= '1;
    end else begin
      srcPrev <= srcIn;
      if (strb.maskWr) maskReg <= maskWrData;
      // a fresh set outranks a simultaneous clear
      pendReg <= (pendReg & ~clrVec) | setVec;
      if (strb.decLoad) decReg <= decWrData;
      else              decReg <= decReg - 1'b1;
    end
  end

  assign maskOut    = maskReg;
  assign selPending = pendReg & maskReg;
  assign anySel     = |selPending;
  assign decValue   = decReg;
endmodule

// File: rtl/evt_control.sv
module evt_control
  import evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       maskWrEn,
  input  logic       ackWrEn,
  input  logic       decWrEn,
  input  logic       intEnSet,
  input  logic       intEnClr,
  input  logic       statRdReq,
  input  logic       anySel,
  output dpStrobes_t strb,
  output logic       irq,
  output logic       statRdValid,
  output logic       statCount
);
  logic intEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         intEn <= 1'b0;
    else if (intEnClr) intEn <= 1'b0;
    else if (intEnSet) intEn <= 1'b1;
  end

  always_comb begin
    strb.maskWr  = maskWrEn;
    strb.ackWr   = ackWrEn;
    strb.decLoad = decWrEn;
  end

  assign irq         = intEn & anySel;
  assign statRdValid = statRdReq & anySel;
  assign statCount   = anySel;
endmodule

// File: rtl/evt_status_ctrl.sv
module evt_status_ctrl
  import evt_pkg::*;
#(
  parameter int NUM_EVT  = 12,
  parameter int DEC_W    = 32,
  parameter int DEC_BIT  = 4,
  parameter int VEC_W    = 16,
  parameter int VEC_ADDR = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] srcIn,
  input  logic               maskWrEn,
  input  logic [NUM_EVT-1:0] maskWrData,
  output logic [NUM_EVT-1:0] maskOut,
  input  logic               ackWrEn,
  input  logic [NUM_EVT-1:0] ackWrData,
  input  logic               statRdReq,
  output logic               statRdValid,
  output logic [NUM_EVT-1:0] statRdData,
  output logic               statCount,
  input  logic               intEnSet,
  input  logic               intEnClr,
  output logic               irq,
  output logic [VEC_W-1:0]   irqVec,
  input  logic               decWrEn,
  input  logic [DEC_W-1:0]   decWrData,
  output logic [DEC_W-1:0]   decValue
);
  dpStrobes_t strb;
  logic       anySel;

  evt_control u_ctrl (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .ackWrEn(ackWrEn),
    .decWrEn(decWrEn), .intEnSet(intEnSet), .intEnClr(intEnClr),
    .statRdReq(statRdReq), .anySel(anySel), .strb(strb), .irq(irq),
    .statRdValid(statRdValid), .statCount(statCount)
  );

  evt_datapath #(.NUM_EVT(NUM_EVT), .DEC_W(DEC_W), .DEC_BIT(DEC_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcIn(srcIn),
    .maskWrData(maskWrData), .ackWrData(ackWrData), .decWrData(decWrData),
    .maskOut(maskOut), .selPending(statRdData), .anySel(anySel),
    .decValue(decValue)
  );

  assign irqVec = VEC_W'(VEC_ADDR);
endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk #(
  parameter int NUM_EVT = 12,
  parameter int DEC_W   = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] maskOut,
  input logic               statRdReq,
  input logic               statRdValid,
  input logic [NUM_EVT-1:0] statRdData,
  input logic               statCount,
  input logic               intEnClr,
  input logic               irq,
  input logic               decWrEn,
  input logic [DEC_W-1:0]   decWrData,
  input logic [DEC_W-1:0]   decValue
);
  // R3
  unmasked_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statRdData & ~maskOut) == '0);
  // R4
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    statCount == (statRdData != '0));
  // R5
  read_served_chk: assert property (@(posedge clk) disable iff (!rstN)
    statRdValid |-> (statRdReq && statRdData != '0));
  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    intEnClr |=> !irq);
  // R10
  irq_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> statCount);
  // R8
  dec_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    decWrEn |=> decValue == $past(decWrData));
  // R8
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decWrEn |=> decValue == $past(decValue) - 1'b1);
endmodule

bind evt_status_ctrl evt_status_chk #(.NUM_EVT(NUM_EVT), .DEC_W(DEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .maskOut(maskOut), .statRdReq(statRdReq),
  .statRdValid(statRdValid), .statRdData(statRdData), .statCount(statCount),
  .intEnClr(intEnClr), .irq(irq), .decWrEn(decWrEn), .decWrData(decWrData),
  .decValue(decValue)
);

// File: tb/evt_status_ctrl_test.sv
module evt_status_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] srcIn, maskWrData, ackWrData, maskOut, statRdData;
  logic        maskWrEn, ackWrEn, statRdReq, statRdValid, statCount;
  logic        intEnSet, intEnClr, irq, decWrEn;
  logic [15:0] irqVec;
  logic [31:0] decWrData, decValue;
  int          nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_status_ctrl uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .maskOut(maskOut), .ackWrEn(ackWrEn),
    .ackWrData(ackWrData), .statRdReq(statRdReq), .statRdValid(statRdValid),
    .statRdData(statRdData), .statCount(statCount), .intEnSet(intEnSet),
    .intEnClr(intEnClr), .irq(irq), .irqVec(irqVec), .decWrEn(decWrEn),
    .decWrData(decWrData), .decValue(decValue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one edge, then settle just after it
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic setMask(input logic [11:0] m);
    maskWrEn = 1'b1; maskWrData = m; tick(); maskWrEn = 1'b0;
  endtask

  task automatic ack(input logic [11:0] a);
    ackWrEn = 1'b1; ackWrData = a; tick(); ackWrEn = 1'b0; ackWrData = '0;
  endtask

  task automatic testReset();
    chk("R1 pending", 32'(statRdData), 0);
    chk("R1 mask", 32'(maskOut), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 count", 32'(statCount), 0);
    chk("R1 valid", 32'(statRdValid), 0);
    chk("R1 dec", decValue, 32'hFFFF_FFFF);
  endtask

  task automatic testEdge();
    setMask(12'hFFF);
    srcIn[2] = 1'b1; tick();
    chk("R2 rise sets", 32'(statRdData), 32'h004);
    chk("R4 count one", 32'(statCount), 1);
    ack(12'h004);
    chk("R6 ack clears", 32'(statRdData), 0);
    tick();
    chk("R2 held level", 32'(statRdData), 0);
    chk("R4 count zero", 32'(statCount), 0);
    srcIn[2] = 1'b0; tick();
    srcIn[2] = 1'b1; tick();
    chk("R6 sets again", 32'(statRdData), 32'h004);
    srcIn[2] = 1'b0; ack(12'h004);
  endtask

  task automatic testMask();
    srcIn[0] = 1'b1; srcIn[7] = 1'b1; tick();
    chk("R3 both", 32'(statRdData), 32'h081);
    setMask(12'h080);
    chk("R3 filtered", 32'(statRdData), 32'h080);
    chk("R3 mask out", 32'(maskOut), 32'h080);
    setMask(12'h000);
    chk("R3 all hidden", 32'(statRdData), 0);
    chk("R4 hidden count", 32'(statCount), 0);
    setMask(12'hFFF);
    ack(12'h001);
    chk("R6 partial ack", 32'(statRdData), 32'h080);
    srcIn[0] = 1'b0; srcIn[7] = 1'b0; ack(12'h080);
  endtask

  task automatic testBlockRead();
    statRdReq = 1'b1; tick();
    chk("R5 stall", 32'(statRdValid), 0);
    tick();
    chk("R5 still stall", 32'(statRdValid), 0);
    srcIn[9] = 1'b1; tick();
    chk("R5 served", 32'(statRdValid), 1);
    chk("R5 data", 32'(statRdData), 32'h200);
    statRdReq = 1'b0; srcIn[9] = 1'b0; ack(12'h200);
  endtask

  task automatic testCollide();
    srcIn[5] = 1'b1; tick(); srcIn[5] = 1'b0; tick();
    ackWrEn = 1'b1; ackWrData = 12'h060; srcIn[5] = 1'b1; srcIn[6] = 1'b1; tick();
    ackWrEn = 1'b0; ackWrData = '0;
    chk("R7 set beats ack", 32'(statRdData), 32'h060);
    ack(12'h060);
    chk("R2 no refire", 32'(statRdData), 0);
    srcIn[5] = 1'b0; srcIn[6] = 1'b0; tick();
  endtask

  task automatic testDec();
    decWrEn = 1'b1; decWrData = 32'd3; tick(); decWrEn = 1'b0;
    chk("R8 load", decValue, 3);
    tick(); tick();
    chk("R8 step", decValue, 1);
    tick();
    chk("R9 at zero no event", 32'(statRdData), 0);
    tick();
    chk("R9 cross value", decValue, 32'hFFFF_FFFF);
    chk("R9 cross event", 32'(statRdData), 32'h010);
    ack(12'h010);
    decWrEn = 1'b1; decWrData = 32'hFFFF_FFF0; tick(); decWrEn = 1'b0;
    tick(); tick(); tick();
    chk("R9 negative no event", 32'(statRdData), 0);
    chk("R8 negative step", decValue, 32'hFFFF_FFED);
    srcIn[4] = 1'b1; tick(); srcIn[4] = 1'b0;
    chk("R9 source bit4", 32'(statRdData), 32'h010);
    ack(12'h010);
  endtask

  task automatic testIrq();
    srcIn[1] = 1'b1; tick(); srcIn[1] = 1'b0;
    chk("R10 disabled", 32'(irq), 0);
    intEnSet = 1'b1; tick(); intEnSet = 1'b0;
    chk("R10 enabled", 32'(irq), 1);
    chk("R11 vector", 32'(irqVec), 0);
    setMask(12'h000);
    chk("R10 masked", 32'(irq), 0);
    setMask(12'hFFF);
    chk("R10 unmasked", 32'(irq), 1);
    intEnClr = 1'b1; tick(); intEnClr = 1'b0;
    chk("R10 cleared", 32'(irq), 0);
    intEnSet = 1'b1; intEnClr = 1'b1; tick(); intEnSet = 1'b0; intEnClr = 1'b0;
    chk("R10 clear wins", 32'(irq), 0);
    ack(12'h002);
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    rstN = 1'b0; srcIn = '0; maskWrEn = 1'b0; maskWrData = '0; ackWrEn = 1'b0;
    ackWrData = '0; statRdReq = 1'b0; intEnSet = 1'b0; intEnClr = 1'b0;
    decWrEn = 1'b0; decWrData = '0;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    tick();
    testEdge();
    testMask();
    testBlockRead();
    testCollide();
    testDec();
    testIrq();
    finish();
  end
endmodule